// File: doc/BRIEF.md
# Cache Line Refill Controller

This controller runs the refill of one data-cache line after a miss. When a miss is accepted it clears the target line's valid bit. In the following cycle it issues a single block request that carries a command, the quadword-aligned miss address and the set chosen for replacement. If the victim line holds valid, modified data, the controller first streams that line back to memory as eight indexed beats. Only after that does it open its response port.

After the memory's command/address response, the new line arrives as eight 8-byte beats. The quadword that missed comes first and the rest follow in wrap-around order. Each beat is written into the data array in the cycle it arrives. The first beat is also handed to the waiting requester in that same cycle. The tag and valid bit are written together with the eighth beat, so a lookup to the line misses until the refill completes. A one-cycle done pulse then returns the controller to idle.

Top module: `refill_ctrl`

## Requirements
- R1: After reset, `miss_ready_o` is 1, and `req_valid_o`, `wb_valid_o`, `resp_ready_o`, `arr_we_o`, `fwd_valid_o`, `tag_we_o` and `done_o` are 0.
- R2: `miss_ready_o` is 1 only while idle, and a miss is accepted only when `miss_valid_i` and `miss_ready_o` are both 1. A miss presented while busy is ignored: it does not change the address, set or tag used by the refill in progress.
- R3: In the accept cycle `vld_clr_o` is 1. In the next cycle, and only then, `req_valid_o` is 1, with `req_addr_o` = miss address with bits [2:0] cleared, `req_set_o` = miss set, and `req_cmd_o` = 2'b01 for a clean victim or 2'b11 when the victim is valid and dirty.
- R4: If the victim is valid and dirty, the controller issues eight writeback beats with `wb_valid_o` = 1. `wb_idx_o` runs 0 to 7 in order and advances only on a cycle with `wb_ready_i` = 1. `wb_addr_o` = {victim address [31:6], `wb_idx_o`, 3'b000}.
- R5: `resp_ready_o` is 1 only after all writeback beats are done and before the response is taken. Fill beats presented before the response cause no array write.
- R6: Fill beat k (k = 0..7) is written in its arrival cycle. On that cycle `arr_we_o` = 1, `arr_idx_o` = (c + k) mod 8 where c = miss address bits [5:3], `arr_set_o` = miss set, and `arr_data_o` = `fill_data_i`.
- R7: On the first fill beat, `fwd_valid_o` = 1 and `fwd_data_o` = `fill_data_i` in the same cycle. `fwd_valid_o` is 0 on every other beat.
- R8: `tag_we_o` is 1 only on the cycle of the eighth fill beat, with `tag_o` = miss address bits [31:6] and `tag_set_o` = miss set.
- R9: A cycle with `fill_valid_i` = 0 during the fill writes nothing and does not advance the beat order.
- R10: In the cycle after the eighth beat, `done_o` is 1 and `miss_ready_o` is 0. In the cycle after that, `miss_ready_o` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | Miss presented |
| miss_ready_o | output | 1 | Controller idle, miss accepted |
| miss_addr_i | input | 32 | Byte address of the miss |
| miss_set_i | input | 2 | Set chosen for replacement |
| victim_valid_i | input | 1 | Victim line valid |
| victim_dirty_i | input | 1 | Victim line modified |
| victim_addr_i | input | 32 | Address of the victim line |
| vld_clr_o | output | 1 | Clear the target line's valid bit |
| req_valid_o | output | 1 | Block request strobe |
| req_cmd_o | output | 2 | Request command |
| req_addr_o | output | 32 | Quadword-aligned miss address |
| req_set_o | output | 2 | Replacement set |
| wb_valid_o | output | 1 | Writeback beat valid |
| wb_ready_i | input | 1 | Writeback beat taken |
| wb_idx_o | output | 3 | Writeback quadword index |
| wb_addr_o | output | 32 | Writeback beat address |
| resp_ready_o | output | 1 | Ready for command/address response |
| resp_valid_i | input | 1 | Memory response valid |
| fill_valid_i | input | 1 | Fill beat valid |
| fill_data_i | input | 64 | Fill beat data |
| arr_we_o | output | 1 | Data array write enable |
| arr_set_o | output | 2 | Data array set |
| arr_idx_o | output | 3 | Data array quadword index |
| arr_data_o | output | 64 | Data array write data |
| fwd_valid_o | output | 1 | Critical quadword to requester |
| fwd_data_o | output | 64 | Critical quadword data |
| tag_we_o | output | 1 | Tag and valid write |
| tag_set_o | output | 2 | Set for tag write |
| tag_o | output | 26 | Tag written |
| done_o | output | 1 | Refill finished |

## Verification
The bench uses critical quadwords at index 0, in the middle of the line and at index 7. This exposes an array index that fails to wrap or that starts from zero instead of the critical index. A dirty victim is run with writeback backpressure. A controller that counted stalled cycles as beats, or that opened the response port early, would show a skipped `wb_idx_o` or a raised `resp_ready_o`. Fill beats sent before the response, and a gap in the middle of the fill, catch a design that writes or counts beats without a valid. A second miss sent during a refill catches a design that captures new addresses while busy, because its tag would then change.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WB    = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FILL  = 3'd3,
    ST_DONE  = 3'd4
  } refill_state_e;

  localparam logic [1:0] CMD_RD    = 2'b01;
  localparam logic [1:0] CMD_RD_WB = 2'b11;
endpackage

// File: rtl/refill_beat_cnt.sv
module refill_beat_cnt #(
  parameter int BEATS = 8,
  localparam int CW = $clog2(BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= (cnt_q == CW'(BEATS-1)) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CW'(BEATS-1));
endmodule

// File: rtl/refill_fsm.sv
module refill_fsm
  import refill_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          need_wb_i,
  input  logic          wb_last_fire_i,
  input  logic          resp_fire_i,
  input  logic          fill_last_fire_i,
  output refill_state_e state_o
);
  refill_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_i)         state_d = need_wb_i ? ST_WB : ST_WAIT;
      ST_WB:   if (wb_last_fire_i)   state_d = ST_WAIT;
      ST_WAIT: if (resp_fire_i)      state_d = ST_FILL;
      ST_FILL: if (fill_last_fire_i) state_d = ST_DONE;
      ST_DONE:                       state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int LINE_BYTES = 64,
  parameter int SETW       = 2,
  localparam int BEAT_BYTES = DW / 8,
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
  localparam int QOFF       = $clog2(BEAT_BYTES),
  localparam int OFFW       = $clog2(LINE_BYTES),
  localparam int IDXW       = OFFW - QOFF,
  localparam int TAGW       = AW - OFFW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            miss_valid_i,
  output logic            miss_ready_o,
  input  logic [AW-1:0]   miss_addr_i,
  input  logic [SETW-1:0] miss_set_i,
  input  logic            victim_valid_i,
  input  logic            victim_dirty_i,
  input  logic [AW-1:0]   victim_addr_i,
  output logic            vld_clr_o,
  output logic            req_valid_o,
  output logic [1:0]      req_cmd_o,
  output logic [AW-1:0]   req_addr_o,
  output logic [SETW-1:0] req_set_o,
  output logic            wb_valid_o,
  input  logic            wb_ready_i,
  output logic [IDXW-1:0] wb_idx_o,
  output logic [AW-1:0]   wb_addr_o,
  output logic            resp_ready_o,
  input  logic            resp_valid_i,
  input  logic            fill_valid_i,
  input  logic [DW-1:0]   fill_data_i,
  output logic            arr_we_o,
  output logic [SETW-1:0] arr_set_o,
  output logic [IDXW-1:0] arr_idx_o,
  output logic [DW-1:0]   arr_data_o,
  output logic            fwd_valid_o,
  output logic [DW-1:0]   fwd_data_o,
  output logic            tag_we_o,
  output logic [SETW-1:0] tag_set_o,
  output logic [TAGW-1:0] tag_o,
  output logic            done_o
);
  refill_state_e state;
  logic accept, need_wb, wb_fire, fill_fire, resp_fire;
  logic [IDXW-1:0] cnt;
  logic cnt_last;

  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   vaddr_q;
  logic [SETW-1:0] set_q;
  logic            wb_q;
  logic            req_q;

  assign need_wb   = victim_valid_i & victim_dirty_i;
  assign accept    = miss_valid_i & (state == ST_IDLE);
  assign wb_fire   = (state == ST_WB) & wb_ready_i;
  assign resp_fire = (state == ST_WAIT) & resp_valid_i;
  assign fill_fire = (state == ST_FILL) & fill_valid_i;

  refill_fsm u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .accept_i         (accept),
    .need_wb_i        (need_wb),
    .wb_last_fire_i   (wb_fire & cnt_last),
    .resp_fire_i      (resp_fire),
    .fill_last_fire_i (fill_fire & cnt_last),
    .state_o          (state)
  );

  // one counter serves writeback then fill; it wraps to zero after each pass
  refill_beat_cnt #(.BEATS(BEATS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (wb_fire | fill_fire),
    .cnt_o  (cnt),
    .last_o (cnt_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      vaddr_q <= '0;
      set_q   <= '0;
      wb_q    <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= accept;
      if (accept) begin
        addr_q  <= miss_addr_i;
        vaddr_q <= victim_addr_i;
        set_q   <= miss_set_i;
        wb_q    <= need_wb;
      end
    end
  end

  assign miss_ready_o = (state == ST_IDLE);
  assign vld_clr_o    = accept;

  assign req_valid_o = req_q;
  assign req_cmd_o   = wb_q ? CMD_RD_WB : CMD_RD;
  assign req_addr_o  = {addr_q[AW-1:QOFF], {QOFF{1'b0}}};
  assign req_set_o   = set_q;

  assign wb_valid_o = (state == ST_WB);
  assign wb_idx_o   = cnt;
  assign wb_addr_o  = {vaddr_q[AW-1:OFFW], cnt, {QOFF{1'b0}}};

  assign resp_ready_o = (state == ST_WAIT);

  // beat k lands at (critical + k) mod BEATS
  assign arr_we_o   = fill_fire;
  assign arr_set_o  = set_q;
  assign arr_idx_o  = addr_q[OFFW-1:QOFF] + cnt;
  assign arr_data_o = fill_data_i;

  assign fwd_valid_o = fill_fire & (cnt == '0);
  assign fwd_data_o  = fill_data_i;

  assign tag_we_o  = fill_fire & cnt_last;
  assign tag_set_o = set_q;
  assign tag_o     = addr_q[AW-1:OFFW];

  assign done_o = (state == ST_DONE);
endmodule

// File: rtl/refill_ctrl_chk.sv
module refill_ctrl_chk #(
  parameter int AW   = 32,
  parameter int DW   = 64,
  parameter int SETW = 2,
  parameter int IDXW = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            miss_valid_i,
  input logic            miss_ready_o,
  input logic            vld_clr_o,
  input logic            req_valid_o,
  input logic            wb_valid_o,
  input logic            resp_ready_o,
  input logic            resp_valid_i,
  input logic            fill_valid_i,
  input logic [DW-1:0]   fill_data_i,
  input logic            arr_we_o,
  input logic [DW-1:0]   arr_data_o,
  input logic            fwd_valid_o,
  input logic [DW-1:0]   fwd_data_o,
  input logic            tag_we_o,
  input logic            done_o
);
  logic [IDXW:0] beats_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          beats_seen <= '0;
    else if (resp_ready_o & resp_valid_i) beats_seen <= '0;
    else if (arr_we_o)                    beats_seen <= beats_seen + 1'b1;
  end

  // R2
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_clr_o |-> miss_ready_o && miss_valid_i);
  // R3
  req_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_clr_o |=> req_valid_o);
  // R5
  resp_not_in_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resp_ready_o && wb_valid_o));
  // R6
  write_needs_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> fill_valid_i && arr_data_o == fill_data_i);
  // R7
  fwd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> arr_we_o && beats_seen == '0 && fwd_data_o == fill_data_i);
  // R8
  tag_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |-> arr_we_o && beats_seen == (IDXW+1)'(7));
  // R10
  done_after_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |=> done_o && !miss_ready_o);
  // R10
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> miss_ready_o);
endmodule

bind refill_ctrl refill_ctrl_chk #(.AW(AW), .DW(DW), .SETW(SETW), .IDXW(IDXW)) u_chk (.*);

// File: tb/refill_ctrl_tb.sv
module refill_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 0;
  logic        miss_ready;
  logic [31:0] miss_addr = '0;
  logic [1:0]  miss_set = '0;
  logic        victim_valid = 0, victim_dirty = 0;
  logic [31:0] victim_addr = '0;
  logic        vld_clr, req_valid;
  logic [1:0]  req_cmd;
  logic [31:0] req_addr;
  logic [1:0]  req_set;
  logic        wb_valid, wb_ready = 0;
  logic [2:0]  wb_idx;
  logic [31:0] wb_addr;
  logic        resp_ready, resp_valid = 0;
  logic        fill_valid = 0;
  logic [63:0] fill_data = '0;
  logic        arr_we;
  logic [1:0]  arr_set;
  logic [2:0]  arr_idx;
  logic [63:0] arr_data;
  logic        fwd_valid;
  logic [63:0] fwd_data;
  logic        tag_we;
  logic [1:0]  tag_set;
  logic [25:0] tag;
  logic        done;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  refill_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_valid), .miss_ready_o(miss_ready),
    .miss_addr_i(miss_addr), .miss_set_i(miss_set),
    .victim_valid_i(victim_valid), .victim_dirty_i(victim_dirty),
    .victim_addr_i(victim_addr), .vld_clr_o(vld_clr),
    .req_valid_o(req_valid), .req_cmd_o(req_cmd), .req_addr_o(req_addr), .req_set_o(req_set),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_idx_o(wb_idx), .wb_addr_o(wb_addr),
    .resp_ready_o(resp_ready), .resp_valid_i(resp_valid),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .arr_we_o(arr_we), .arr_set_o(arr_set), .arr_idx_o(arr_idx), .arr_data_o(arr_data),
    .fwd_valid_o(fwd_valid), .fwd_data_o(fwd_data),
    .tag_we_o(tag_we), .tag_set_o(tag_set), .tag_o(tag), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_in();
    @(negedge clk);
  endtask

  // full refill; gap inserts an idle fill cycle before beat 3
  task automatic run_miss(input logic [31:0] addr, input logic [1:0] set,
                          input bit vv, input bit vd, input logic [31:0] vaddr, input bit gap);
    bit dirty = vv & vd;
    logic [2:0] crit = addr[5:3];
    step_in();
    miss_valid = 1; miss_addr = addr; miss_set = set;
    victim_valid = vv; victim_dirty = vd; victim_addr = vaddr;
    #1;
    chk(miss_ready == 1, "R2 ready idle", 64'(miss_ready), 64'd1);
    chk(vld_clr == 1, "R3 vld_clr", 64'(vld_clr), 64'd1);
    step_in();
    miss_valid = 0; miss_addr = 32'hFFFF_FFC0; victim_valid = 0; victim_dirty = 0;
    #1;
    chk(req_valid == 1, "R3 req_valid", 64'(req_valid), 64'd1);
    chk(req_cmd == (dirty ? 2'b11 : 2'b01), "R3 req_cmd", 64'(req_cmd), dirty ? 64'd3 : 64'd1);
    chk(req_addr == {addr[31:3], 3'b0}, "R3 req_addr", 64'(req_addr), 64'({addr[31:3], 3'b0}));
    chk(req_set == set, "R3 req_set", 64'(req_set), 64'(set));
    chk(miss_ready == 0, "R2 busy", 64'(miss_ready), 64'd0);
    if (dirty) begin
      wb_ready = 0;
      chk(wb_valid == 1 && wb_idx == 0, "R4 wb stall", 64'({wb_valid, wb_idx}), 64'h8);
      chk(resp_ready == 0, "R5 no resp in wb", 64'(resp_ready), 64'd0);
      for (int k = 0; k < 8; k++) begin
        step_in();
        wb_ready = 1; #1;
        if (k == 0) chk(req_valid == 0, "R3 req one cycle", 64'(req_valid), 64'd0);
        chk(wb_valid == 1 && wb_idx == 3'(k), "R4 wb idx", 64'({wb_valid, wb_idx}), 64'({1'b1, 3'(k)}));
        chk(wb_addr == {vaddr[31:6], 3'(k), 3'b0}, "R4 wb addr", 64'(wb_addr),
            64'({vaddr[31:6], 3'(k), 3'b0}));
        chk(resp_ready == 0, "R5 no resp in wb", 64'(resp_ready), 64'd0);
      end
      step_in(); wb_ready = 0; #1;
      chk(wb_valid == 0, "R4 wb over", 64'(wb_valid), 64'd0);
    end else begin
      chk(wb_valid == 0, "R4 clean no wb", 64'(wb_valid), 64'd0);
      step_in(); #1;
      chk(req_valid == 0, "R3 req one cycle", 64'(req_valid), 64'd0);
    end
    // waiting: early fill and a second miss must both be ignored
    chk(resp_ready == 1, "R5 resp ready", 64'(resp_ready), 64'd1);
    miss_valid = 1; miss_addr = 32'h1234_5678; fill_valid = 1; fill_data = 64'hDEAD;
    #1;
    chk(miss_ready == 0 && vld_clr == 0, "R2 busy ignored", 64'({miss_ready, vld_clr}), 64'd0);
    chk(arr_we == 0 && fwd_valid == 0, "R5 early fill", 64'({arr_we, fwd_valid}), 64'd0);
    step_in();
    miss_valid = 0; fill_valid = 0; resp_valid = 1; #1;
    chk(resp_ready == 1, "R5 resp ready", 64'(resp_ready), 64'd1);
    step_in();
    resp_valid = 0;
    for (int k = 0; k < 8; k++) begin
      logic [2:0] qi = crit + 3'(k);
      logic [63:0] d = {addr, 29'd0, qi};
      if (gap && k == 3) begin
        fill_valid = 0; #1;
        chk(arr_we == 0 && tag_we == 0 && fwd_valid == 0, "R9 gap",
            64'({arr_we, tag_we, fwd_valid}), 64'd0);
        step_in();
      end
      fill_valid = 1; fill_data = d; #1;
      chk(arr_we == 1 && arr_idx == qi, "R6 idx", 64'({arr_we, arr_idx}), 64'({1'b1, qi}));
      chk(arr_data == d && arr_set == set, "R6 data", arr_data, d);
      chk(fwd_valid == (k == 0), "R7 fwd", 64'(fwd_valid), 64'(k == 0));
      if (k == 0) chk(fwd_data == d, "R7 fwd data", fwd_data, d);
      chk(tag_we == (k == 7), "R8 tag we", 64'(tag_we), 64'(k == 7));
      if (k == 7) begin
        chk(tag == addr[31:6], "R8 tag", 64'(tag), 64'(addr[31:6]));
        chk(tag_set == set, "R8 tag set", 64'(tag_set), 64'(set));
      end
      step_in();
    end
    fill_valid = 0; #1;
    chk(done == 1 && miss_ready == 0, "R10 done", 64'({done, miss_ready}), 64'h2);
    chk(arr_we == 0 && tag_we == 0, "R10 quiet", 64'({arr_we, tag_we}), 64'd0);
    step_in(); #1;
    chk(done == 0 && miss_ready == 1, "R10 idle", 64'({done, miss_ready}), 64'h1);
  endtask

  task automatic test_reset();
    #1;
    chk(miss_ready == 1, "R1 ready", 64'(miss_ready), 64'd1);
    chk({req_valid, wb_valid, resp_ready, arr_we, fwd_valid, tag_we, done} == 0, "R1 quiet",
        64'({req_valid, wb_valid, resp_ready, arr_we, fwd_valid, tag_we, done}), 64'd0);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #5;
    test_reset();
    @(negedge clk); rst_n = 1;
    test_reset();
    run_miss(32'h0000_1000, 2'd1, 1'b0, 1'b0, 32'h0, 1'b0);          // critical 0, clean
    run_miss(32'hABCD_E468, 2'd2, 1'b1, 1'b0, 32'h5555_0040, 1'b1);  // critical 5, valid clean, gap
    run_miss(32'h8000_01B8, 2'd3, 1'b1, 1'b1, 32'h7777_7FC0, 1'b0);  // critical 7, dirty
    run_miss(32'h0420_0090, 2'd0, 1'b0, 1'b1, 32'h1111_0000, 1'b1);  // dirty but invalid
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule